// File: doc/BRIEF.md
# Per-Stage Sub-Code Histogram Collector

This block sits beside the digital alignment latches of a pipelined converter whose stages each resolve 1.5 bits. On every valid sample it looks at the 2-bit decision of each stage. It then adds one to the matching bin of that stage. Each stage has three bins, one for each legal decision value. Storage therefore grows as three counters per stage, not as one counter per converter output code.

Collection runs until a fixed number of samples has been accepted. That number is a power of two, so a later estimator can turn bin counts into probabilities with shifts. When the target is reached a done flag rises and stays high, and later samples are ignored.

The estimator reads any bin through a small read port. After it removes errors carried in from earlier stages, it can overwrite any bin in place through a write-back port. A decision value of 11 is illegal: it is counted in no bin and sets a sticky error flag. A synchronous clear empties every bank and drops both flags.

Top module: `stage_code_hist`

## Requirements
- R1: After asynchronous reset every bin reads zero and `done` and `code_err` are low.
- R2: Each accepted sample adds exactly one to one bin per stage, chosen by that stage's code. Stage s takes its code from `smp_codes[2s+1:2s]`. Code 00 selects bin 0, 01 selects bin 1 and 10 selects bin 2. All other bins of the stage hold their value.
- R3: An accepted sample whose stage code is 11 changes no bin of that stage and sets `code_err`. `code_err` stays high until clear.
- R4: While `smp_vld` is low (and there is no write-back or clear), no bin, flag or sample count changes.
- R5: With target T = 2^LOG2_TARGET, `done` rises on the cycle after the T-th accepted sample. After that no sample changes any bin, and `done` stays high until clear.
- R6: A bin at full scale (2^BIN_W - 1) stays at full scale when incremented. It does not wrap.
- R7: `rd_data` combinationally shows bin `rd_bin` of stage `rd_stage`. It shows zero when `rd_bin` is 3.
- R8: `wb_en` loads `wb_data` into bin `wb_bin` of stage `wb_stage` at the next edge. If a sample targets the same bin in that cycle, the write-back wins. A write-back with `wb_bin` of 3 changes nothing.
- R9: `clr` zeroes every bin, `done`, `code_err` and the sample count at the next edge. It takes priority over samples and write-back in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all banks and flags |
| smp_vld | input | 1 | A new set of stage codes is present |
| smp_codes | input | 2*N_STAGES | Packed per-stage 2-bit decisions, stage s at bits 2s+1:2s |
| done | output | 1 | Sample target reached; held until clear |
| code_err | output | 1 | Sticky flag: an illegal code 11 was seen |
| bins_flat | output | 3*N_STAGES*BIN_W | All bins; bin b of stage s at bits (3s+b)*BIN_W upward |
| rd_stage | input | SW | Read port stage select |
| rd_bin | input | 2 | Read port bin select (0..2) |
| rd_data | output | BIN_W | Selected bin value |
| wb_en | input | 1 | Write-back strobe |
| wb_stage | input | SW | Write-back stage select |
| wb_bin | input | 2 | Write-back bin select (0..2) |
| wb_data | input | BIN_W | Value to load |

## Verification
The hardest state to reach from the ports is a bin at full scale. The sample target stops collection well below the counter range, so plain sampling never gets a bin there. The stimulus uses the write-back port to preload a bin just below full scale, then streams samples carrying that code to step the bin across the limit and hold it there.

The same directed phase also covers:
- a write-back and a sample that hit the same bin in one cycle;
- a clear that arrives together with both a sample and a write-back.

Random codes with a fixed seed, including the occasional illegal code and random write-backs, then fill the histogram up to the target and run past it.

// File: rtl/hist_pkg.sv
package hist_pkg;
  typedef enum logic [1:0] {
    SC_LOW  = 2'b00,
    SC_MID  = 2'b01,
    SC_HIGH = 2'b10,
    SC_BAD  = 2'b11
  } subcode_e;

  localparam int BINS_PER_STAGE = 3;
endpackage

// File: rtl/hist_decode.sv
module hist_decode
  import hist_pkg::*;
(
  input  logic       vld,
  input  logic [1:0] code,
  output logic [2:0] hit,
  output logic       bad
);
  always_comb begin
    hit = 3'b000;
    bad = 1'b0;
    if (vld) begin
      case (subcode_e'(code))
        SC_LOW:  hit = 3'b001;
        SC_MID:  hit = 3'b010;
        SC_HIGH: hit = 3'b100;
        default: bad = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/hist_bin.sv
module hist_bin #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] FULL = {W{1'b1}};

  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (clr)                      q_nxt = '0;
    else if (ld)                  q_nxt = ld_val;
    else if (inc && (q != FULL))  q_nxt = q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  // R6
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !ld && inc && q == FULL) |=> (q == FULL));

  // R2
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !ld && inc && q != FULL) |=> (q == $past(q) + W'(1)));

  // R8
  load_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && ld) |=> (q == $past(ld_val)));

  // R9
  clear_bin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0));
endmodule

// File: rtl/hist_seq.sv
module hist_seq #(
  parameter int LOG2_TARGET = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic smp_vld,
  output logic accept,
  output logic done
);
  localparam int CW = LOG2_TARGET + 1;
  localparam logic [CW-1:0] TARGET = CW'(1) << LOG2_TARGET;

  logic [CW-1:0] cnt, cnt_nxt;
  logic          done_nxt;
  logic          at_target;

  assign at_target = (cnt == TARGET);
  assign accept    = smp_vld && !at_target && !clr;

  always_comb begin
    cnt_nxt  = cnt;
    done_nxt = done;
    if (clr) begin
      cnt_nxt  = '0;
      done_nxt = 1'b0;
    end else begin
      if (accept)    cnt_nxt  = cnt + CW'(1);
      if (at_target) done_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      cnt  <= cnt_nxt;
      done <= done_nxt;
    end
  end

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= TARGET);

  // R5
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && at_target) |=> done);

  // R5
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr) |=> done);
endmodule

// File: rtl/stage_code_hist.sv
module stage_code_hist
  import hist_pkg::*;
#(
  parameter int N_STAGES    = 4,
  parameter int BIN_W       = 10,
  parameter int LOG2_TARGET = 8,
  localparam int SW         = (N_STAGES > 1) ? $clog2(N_STAGES) : 1
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 clr,
  input  logic                                 smp_vld,
  input  logic [2*N_STAGES-1:0]                smp_codes,
  output logic                                 done,
  output logic                                 code_err,
  output logic [BINS_PER_STAGE*N_STAGES*BIN_W-1:0] bins_flat,
  input  logic [SW-1:0]                        rd_stage,
  input  logic [1:0]                           rd_bin,
  output logic [BIN_W-1:0]                     rd_data,
  input  logic                                 wb_en,
  input  logic [SW-1:0]                        wb_stage,
  input  logic [1:0]                           wb_bin,
  input  logic [BIN_W-1:0]                     wb_data
);
  localparam int NBINS = BINS_PER_STAGE * N_STAGES;

  logic                accept;
  logic [N_STAGES-1:0] bad_vec;
  logic [BIN_W-1:0]    bank [NBINS];
  logic                err_nxt;

  hist_seq #(.LOG2_TARGET(LOG2_TARGET)) seq_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .smp_vld (smp_vld),
    .accept  (accept),
    .done    (done)
  );

  for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
    logic [2:0] hit;

    hist_decode dec_i (
      .vld  (accept),
      .code (smp_codes[2*s +: 2]),
      .hit  (hit),
      .bad  (bad_vec[s])
    );

    // R3
    bad_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && smp_codes[2*s +: 2] == 2'b11) |-> (hit == 3'b000));

    for (genvar b = 0; b < BINS_PER_STAGE; b++) begin : g_bin
      logic ld;
      assign ld = wb_en && (wb_stage == SW'(s)) && (wb_bin == 2'(b));

      hist_bin #(.W(BIN_W)) bin_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .inc    (hit[b]),
        .ld     (ld),
        .ld_val (wb_data),
        .q      (bank[s*BINS_PER_STAGE + b])
      );

      assign bins_flat[(s*BINS_PER_STAGE + b)*BIN_W +: BIN_W] = bank[s*BINS_PER_STAGE + b];
    end
  end

  always_comb begin
    rd_data = '0;
    for (int s = 0; s < N_STAGES; s++) begin
      for (int b = 0; b < BINS_PER_STAGE; b++) begin
        if ((rd_stage == SW'(s)) && (rd_bin == 2'(b))) rd_data = bank[s*BINS_PER_STAGE + b];
      end
    end
  end

  always_comb begin
    err_nxt = code_err;
    if (clr)           err_nxt = 1'b0;
    else if (|bad_vec) err_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_err <= 1'b0;
    else        code_err <= err_nxt;
  end

  // R3
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_err && !clr) |=> code_err);

  // R4
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_vld && !wb_en && !clr) |=> ($stable(bins_flat) && $stable(code_err)));

  // R9
  clear_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!done && !code_err));

  // R7
  rd_bad_bin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_bin == 2'b11) |-> (rd_data == '0));
endmodule

// File: tb/stage_code_hist_tb_top.sv
module stage_code_hist_tb_top;
  localparam int NS  = 4;
  localparam int BW  = 10;
  localparam int L2T = 8;
  localparam int SW  = 2;
  localparam int TGT = 1 << L2T;
  localparam int FULLV = (1 << BW) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic clr;
  logic smp_vld;
  logic [2*NS-1:0] smp_codes;
  logic done, code_err;
  logic [3*NS*BW-1:0] bins_flat;
  logic [SW-1:0] rd_stage;
  logic [1:0] rd_bin;
  logic [BW-1:0] rd_data;
  logic wb_en;
  logic [SW-1:0] wb_stage;
  logic [1:0] wb_bin;
  logic [BW-1:0] wb_data;

  int errors = 0;
  int checks = 0;
  int exp_bin [NS][3];
  int exp_sc;
  bit exp_done, exp_err;

  always #5 clk = ~clk;

  stage_code_hist #(.N_STAGES(NS), .BIN_W(BW), .LOG2_TARGET(L2T)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .smp_vld(smp_vld), .smp_codes(smp_codes),
    .done(done), .code_err(code_err), .bins_flat(bins_flat),
    .rd_stage(rd_stage), .rd_bin(rd_bin), .rd_data(rd_data),
    .wb_en(wb_en), .wb_stage(wb_stage), .wb_bin(wb_bin), .wb_data(wb_data)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int s = 0; s < NS; s++)
      for (int b = 0; b < 3; b++)
        chk($sformatf("%s bin s%0d b%0d", tag, s, b),
            int'(bins_flat[(s*3+b)*BW +: BW]), exp_bin[s][b]);
    chk({tag, " done"}, int'(done), int'(exp_done));
    chk({tag, " code_err"}, int'(code_err), int'(exp_err));
  endtask

  function automatic int sat_inc(input int v);
    return (v == FULLV) ? v : v + 1;
  endfunction

  // Called at a falling edge: drives one cycle, updates the model, checks after the edge.
  task automatic cyc(input string tag, input bit c, input bit v, input logic [2*NS-1:0] codes,
                     input bit we, input int ws, input int wbn, input int wd);
    int nb [NS][3];
    clr = c; smp_vld = v; smp_codes = codes;
    wb_en = we; wb_stage = SW'(ws); wb_bin = 2'(wbn); wb_data = BW'(wd);
    nb = exp_bin;
    if (c) begin
      for (int s = 0; s < NS; s++) for (int b = 0; b < 3; b++) nb[s][b] = 0;
      exp_sc = 0; exp_done = 0; exp_err = 0;
    end else begin
      bit acc;
      acc = v && (exp_sc != TGT);
      if (exp_sc == TGT) exp_done = 1;
      if (acc) begin
        exp_sc++;
        for (int s = 0; s < NS; s++) begin
          int cd;
          cd = int'(codes[2*s +: 2]);
          if (cd == 3) exp_err = 1;
          else nb[s][cd] = sat_inc(exp_bin[s][cd]);
        end
      end
      if (we && wbn != 3) nb[ws][wbn] = wd;
    end
    exp_bin = nb;
    @(negedge clk);
    check_all(tag);
    clr = 0; smp_vld = 0; wb_en = 0;
  endtask

  function automatic logic [2*NS-1:0] rnd_codes();
    logic [2*NS-1:0] r;
    for (int s = 0; s < NS; s++) begin
      int x;
      x = int'($urandom % 16);
      r[2*s +: 2] = (x == 0) ? 2'b11 : 2'(x % 3);
    end
    return r;
  endfunction

  initial begin
    int dummy;
    dummy = int'($urandom(32'd2718));
    rst_n = 0; clr = 0; smp_vld = 0; smp_codes = '0;
    wb_en = 0; wb_stage = '0; wb_bin = '0; wb_data = '0;
    rd_stage = '0; rd_bin = '0;
    for (int s = 0; s < NS; s++) for (int b = 0; b < 3; b++) exp_bin[s][b] = 0;
    exp_sc = 0; exp_done = 0; exp_err = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R1 reset");

    // stage3=10 stage2=01 stage1=00 stage0=10
    cyc("R2 single", 0, 1, 8'b10_01_00_10, 0, 0, 0, 0);
    cyc("R2 second", 0, 1, 8'b00_00_01_01, 0, 0, 0, 0);
    cyc("R4 vld low", 0, 0, 8'b01_10_01_00, 0, 0, 0, 0);
    cyc("R3 illegal", 0, 1, 8'b01_00_11_00, 0, 0, 0, 0);
    cyc("R3 sticky", 0, 0, 8'b00_00_00_00, 0, 0, 0, 0);

    cyc("R8 load", 0, 0, '0, 1, 2, 1, FULLV - 1);
    cyc("R8 collide", 0, 1, 8'b10_10_01_00, 1, 0, 0, 5);
    cyc("R8 bin3 ignored", 0, 0, '0, 1, 1, 3, 77);

    cyc("R6 step to full", 0, 1, 8'b00_01_00_00, 0, 0, 0, 0);
    cyc("R6 hold full", 0, 1, 8'b00_01_00_00, 0, 0, 0, 0);
    cyc("R6 hold again", 0, 1, 8'b01_01_10_01, 0, 0, 0, 0);

    for (int s = 0; s < NS; s++) begin
      for (int b = 0; b < 4; b++) begin
        rd_stage = SW'(s); rd_bin = 2'(b);
        #1;
        chk($sformatf("R7 read s%0d b%0d", s, b), int'(rd_data), (b == 3) ? 0 : exp_bin[s][b]);
      end
    end
    @(negedge clk);

    cyc("R9 clear priority", 1, 1, 8'b00_00_00_00, 1, 0, 0, 9);

    for (int i = 0; i < 150; i++) begin
      bit v, we;
      v  = ($urandom % 4) != 0;
      we = ($urandom % 8) == 0;
      cyc("R2 random", 0, v, rnd_codes(), we, int'($urandom % NS), int'($urandom % 4),
          int'($urandom % (FULLV + 1)));
    end

    cyc("R9 clear", 1, 0, '0, 0, 0, 0, 0);
    while (exp_sc < TGT) cyc("R5 fill", 0, 1, rnd_codes(), 0, 0, 0, 0);
    chk("R5 done not yet", int'(done), 0);
    cyc("R5 done rises", 0, 1, 8'b00_00_00_00, 0, 0, 0, 0);
    for (int i = 0; i < 6; i++) cyc("R5 ignored after done", 0, 1, 8'b01_01_01_01, 0, 0, 0, 0);
    cyc("R9 clear done", 1, 0, '0, 0, 0, 0, 0);
    cyc("R1 idle after clear", 0, 0, '0, 0, 0, 0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule